// File: doc/BRIEF.md
# Auto-Reload Periodic Tick Timer

This block produces a steady system tick from one 16-bit down-counter. The input clock first goes through an 8-bit prescaler. A second stage then either halves the prescaled rate or switches over to an external tick input. Software programs the block through a small synchronous register port. It writes a count buffer and a compare buffer, and these values reach the live counter only through a manual-update bit in the control register or through an automatic reload when the counter wraps.

Each wrap sets a sticky pending flag. That flag drives the interrupt output and stays set until software writes a one to the clear register. The live counter can be read at any time, so software can work out how much time has passed since the last tick. With auto-reload turned off the counter makes a single pass, raises the flag once and then rests at zero.

Top module: `tick_timer`

## Requirements
- R1: After synchronous reset the interrupt output and compare-hit output are low, and the observation register (0x14) reads zero.
- R2: While control bit 21 (manual update) is set, the count buffer and compare buffer are copied into the live counter and live compare every cycle, and the live counter stops decrementing.
- R3: The count buffer (0x0C) reads back as written, and writing it alone does not change the observation register.
- R4: With mux select (0x04 bit 0) at 0, start (control bit 20) set and auto-reload (control bit 22) set, the flag sets once every 2*(N+1)*(P+1) clocks, where N is the count buffer value and P is the prescaler (0x00 bits 7:0). This holds for N = 0.
- R5: Raising the prescaler value P stretches the period by a factor of P+1.
- R6: A new count buffer value written while the counter runs takes effect at the next reload. The period in progress is not affected.
- R7: With auto-reload clear, the counter stops at zero after one pass. The flag is raised once and is not raised again.
- R8: The pending flag reads in bit 0 of 0x18. It is sticky. Writing 0x18 with bit 0 set clears it, and writing 0x18 with bit 0 clear has no effect.
- R9: When start is clear, the counter holds its value.
- R10: With mux select at 1, the counter decrements once per rising edge of the external tick (after synchronisation). A wrap raises the flag and reloads the count buffer.
- R11: The compare-hit output is high while the timer runs and the live counter equals the live compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_tick | input | 1 | External tick source, asynchronous |
| bus_sel | input | 1 | Register port select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data is valid the next cycle |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Pending flag, active high |
| cmp_hit | output | 1 | Registered counter-equals-compare indication |

## Verification
The bench uses the default widths: a 16-bit counter and an 8-bit prescaler. Count values are kept small (0, 2, 3, 5, 6 and 100) and prescaler values are 0, 2 and 3, so that a run of several periods, the N = 0 corner and a buffer change at reload all fit in a short run. In external mode the ticks are slow, so the counter sits still between them. That lets the bench check exact counter values and the compare match.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int OFF_PSC  = 'h00;
  localparam int OFF_MUX  = 'h04;
  localparam int OFF_CTL  = 'h08;
  localparam int OFF_CBUF = 'h0C;
  localparam int OFF_MBUF = 'h10;
  localparam int OFF_OBS  = 'h14;
  localparam int OFF_PEND = 'h18;
  localparam int CTL_START  = 20;
  localparam int CTL_MANUAL = 21;
  localparam int CTL_AUTO   = 22;
  typedef enum logic {SRC_DIV2 = 1'b0, SRC_EXT = 1'b1} tick_src_e;
endpackage

// File: rtl/tick_extsync.sv
module tick_extsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/tick_prescale.sv
module tick_prescale
  import tick_timer_pkg::*;
#(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PSC_W-1:0] psc,
  input  tick_src_e        src,
  input  logic             ext_rise,
  output logic             tick
);
  logic [PSC_W-1:0] pcnt_q;
  logic             half_q;
  logic             pre_stb;

  assign pre_stb = run && (pcnt_q == psc);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pcnt_q <= '0;
      half_q <= 1'b0;
    end else if (pre_stb) begin
      pcnt_q <= '0;
      half_q <= ~half_q;
    end else begin
      pcnt_q <= pcnt_q + 1'b1;
    end
  end

  always_comb begin
    if (src == SRC_EXT) tick = run && ext_rise;
    else                tick = pre_stb && half_q;
  end
endmodule

// File: rtl/tick_downcount.sv
module tick_downcount #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic             auto_rl,
  input  logic [CNT_W-1:0] cbuf,
  input  logic [CNT_W-1:0] mbuf,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cmp,
  output logic             wrap
);
  logic expired_q;

  assign wrap = tick && !load && !expired_q && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      cmp       <= '0;
      expired_q <= 1'b0;
    end else if (load) begin
      cnt       <= cbuf;
      cmp       <= mbuf;
      expired_q <= 1'b0;
    end else if (wrap) begin
      if (auto_rl) cnt <= cbuf;
      else         expired_q <= 1'b1;
    end else if (tick && !expired_q) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 8,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_tick,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              cmp_hit
);
  localparam logic [ADDR_W-1:0] A_PSC  = ADDR_W'(OFF_PSC);
  localparam logic [ADDR_W-1:0] A_MUX  = ADDR_W'(OFF_MUX);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(OFF_CTL);
  localparam logic [ADDR_W-1:0] A_CBUF = ADDR_W'(OFF_CBUF);
  localparam logic [ADDR_W-1:0] A_MBUF = ADDR_W'(OFF_MBUF);
  localparam logic [ADDR_W-1:0] A_OBS  = ADDR_W'(OFF_OBS);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFF_PEND);

  logic [PSC_W-1:0] psc_q;
  tick_src_e        src_q;
  logic             start_q, manual_q, auto_q;
  logic [CNT_W-1:0] cbuf_q, mbuf_q;
  logic [CNT_W-1:0] cnt_live, cmp_live;
  logic             pend_q, wrap, tick, ext_rise;
  logic             wr_en, pend_clr;

  assign wr_en    = bus_sel && bus_wr;
  assign pend_clr = wr_en && (bus_addr == A_PEND) && bus_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      psc_q    <= '0;
      src_q    <= SRC_DIV2;
      start_q  <= 1'b0;
      manual_q <= 1'b0;
      auto_q   <= 1'b0;
      cbuf_q   <= '0;
      mbuf_q   <= '0;
    end else if (wr_en) begin
      case (bus_addr)
        A_PSC:  psc_q  <= bus_wdata[PSC_W-1:0];
        A_MUX:  src_q  <= tick_src_e'(bus_wdata[0]);
        A_CTL: begin
          start_q  <= bus_wdata[CTL_START];
          manual_q <= bus_wdata[CTL_MANUAL];
          auto_q   <= bus_wdata[CTL_AUTO];
        end
        A_CBUF: cbuf_q <= bus_wdata[CNT_W-1:0];
        A_MBUF: mbuf_q <= bus_wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  tick_extsync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .din(ext_tick), .rise(ext_rise)
  );

  tick_prescale #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst(rst), .run(start_q), .psc(psc_q), .src(src_q),
    .ext_rise(ext_rise), .tick(tick)
  );

  tick_downcount #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .load(manual_q), .auto_rl(auto_q),
    .cbuf(cbuf_q), .mbuf(mbuf_q), .cnt(cnt_live), .cmp(cmp_live), .wrap(wrap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= 1'b0;
      cmp_hit <= 1'b0;
    end else begin
      if (wrap)          pend_q <= 1'b1;
      else if (pend_clr) pend_q <= 1'b0;
      cmp_hit <= start_q && (cnt_live == cmp_live);
    end
  end

  assign irq = pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_sel && bus_rd) begin
      bus_rdata <= '0;
      case (bus_addr)
        A_PSC:  bus_rdata[PSC_W-1:0] <= psc_q;
        A_MUX:  bus_rdata[0] <= src_q;
        A_CTL: begin
          bus_rdata[CTL_START]  <= start_q;
          bus_rdata[CTL_MANUAL] <= manual_q;
          bus_rdata[CTL_AUTO]   <= auto_q;
        end
        A_CBUF: bus_rdata[CNT_W-1:0] <= cbuf_q;
        A_MBUF: bus_rdata[CNT_W-1:0] <= mbuf_q;
        A_OBS:  bus_rdata[CNT_W-1:0] <= cnt_live;
        A_PEND: bus_rdata[0] <= pend_q;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             irq,
  input logic             pend_clr,
  input logic             start_q,
  input logic             manual_q,
  input logic             auto_q,
  input logic [CNT_W-1:0] cbuf_q,
  input logic [CNT_W-1:0] cnt_live
);
  // R1: the flag is low in the first cycle after reset
  a_r1_irq_after_reset: assert property (@(posedge clk) rst |=> !irq);

  a_r8_pend_sticky: assert property (@(posedge clk) disable iff (rst)
    (irq && !pend_clr) |=> irq);

  a_r2_manual_load: assert property (@(posedge clk) disable iff (rst)
    manual_q |=> (cnt_live == $past(cbuf_q)));

  a_r9_stop_hold: assert property (@(posedge clk) disable iff (rst)
    (!start_q && !manual_q) |=> $stable(cnt_live));

  a_r7_oneshot_rest: assert property (@(posedge clk) disable iff (rst)
    (!auto_q && !manual_q && cnt_live == '0) |=> (cnt_live == '0));

  a_r4_step_or_hold: assert property (@(posedge clk) disable iff (rst)
    (!manual_q && cnt_live != '0) |=>
      (cnt_live == $past(cnt_live) || cnt_live == $past(cnt_live) - 1'b1));
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .irq(irq), .pend_clr(pend_clr), .start_q(start_q),
  .manual_q(manual_q), .auto_q(auto_q), .cbuf_q(cbuf_q), .cnt_live(cnt_live)
);

// File: tb/tick_timer_tb.sv
module tick_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ext_tick = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, cmp_hit;

  int n_chk = 0, n_bad = 0;
  int cyc = 0, nrise = 0, t_prev = 0, t_last = 0;
  logic irq_seen = 1'b0;
  logic [31:0] rv;

  localparam logic [31:0] C_START = 32'h1 << 20;
  localparam logic [31:0] C_MAN   = 32'h1 << 21;
  localparam logic [31:0] C_AUTO  = 32'h1 << 22;

  always #10 clk = ~clk;

  tick_timer dut_i (
    .clk(clk), .rst(rst), .ext_tick(ext_tick), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .cmp_hit(cmp_hit)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (irq && !irq_seen) begin
      t_prev = t_last;
      t_last = cyc;
      nrise  = nrise + 1;
    end
    irq_seen = irq;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 5'(a); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = 5'(a);
    @(negedge clk);
    bus_sel = 1'b0; bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ext_pulse();
    @(negedge clk); ext_tick = 1'b1;
    idle(3);
    ext_tick = 1'b0;
    idle(4);
  endtask

  task automatic wait_rise(input int k);
    while (nrise < k) @(negedge clk);
  endtask

  task automatic stop_all();
    wr('h08, 32'h0);
    wr('h18, 32'h1);
    idle(2);
  endtask

  task automatic t_reset();
    chk("R1 irq", irq, 0);
    chk("R1 cmp_hit", cmp_hit, 0);
    rd('h14, rv);
    chk("R1 observe", rv, 0);
  endtask

  task automatic t_load();
    wr('h0C, 32'd5);
    rd('h0C, rv);
    chk("R3 buffer readback", rv, 5);
    rd('h14, rv);
    chk("R3 buffer isolated", rv, 0);
    wr('h08, C_MAN);
    wr('h08, 32'h0);
    rd('h14, rv);
    chk("R2 manual copy", rv, 5);
    idle(10);
    rd('h14, rv);
    chk("R9 stopped hold", rv, 5);
  endtask

  task automatic t_period(input int n, input int p, input string req);
    int base;
    wr('h00, p); wr('h04, 0); wr('h0C, n);
    wr('h08, C_MAN | C_AUTO);
    wr('h08, C_START | C_AUTO);
    base = nrise;
    for (int k = 1; k <= 3; k++) begin
      wait_rise(base + k);
      wr('h18, 32'h1);
    end
    chk(req, t_last - t_prev, 2 * (n + 1) * (p + 1));
    stop_all();
  endtask

  task automatic t_reload_change();
    int base;
    wr('h00, 0); wr('h04, 0); wr('h0C, 3);
    wr('h08, C_MAN | C_AUTO);
    wr('h08, C_START | C_AUTO);
    base = nrise;
    wait_rise(base + 1);
    wr('h0C, 6);
    wr('h18, 32'h1);
    wait_rise(base + 2);
    chk("R6 old period kept", t_last - t_prev, 8);
    wr('h18, 32'h1);
    wait_rise(base + 3);
    chk("R6 new period", t_last - t_prev, 14);
    stop_all();
  endtask

  task automatic t_stop();
    logic [31:0] a;
    wr('h00, 0); wr('h0C, 100);
    wr('h08, C_MAN | C_AUTO);
    wr('h08, C_START | C_AUTO);
    idle(20);
    wr('h08, C_AUTO);
    rd('h14, a);
    chk("R9 counter moved before stop", int'(a < 100), 1);
    idle(10);
    rd('h14, rv);
    chk("R9 hold after stop", rv, a);
    stop_all();
  endtask

  task automatic t_oneshot();
    int base;
    wr('h00, 0); wr('h0C, 2);
    wr('h08, C_MAN);
    wr('h08, C_START);
    base = nrise;
    wait_rise(base + 1);
    rd('h18, rv);
    chk("R8 pending read", rv[0], 1);
    wr('h18, 32'h0);
    rd('h18, rv);
    chk("R8 write zero ignored", rv[0], 1);
    wr('h18, 32'h1);
    rd('h18, rv);
    chk("R8 clear", rv[0], 0);
    idle(40);
    chk("R7 single raise", irq, 0);
    rd('h14, rv);
    chk("R7 rest at zero", rv, 0);
    stop_all();
  endtask

  task automatic t_ext();
    wr('h04, 1); wr('h0C, 3); wr('h10, 2);
    wr('h08, C_MAN | C_AUTO);
    wr('h08, C_START | C_AUTO);
    idle(3);
    chk("R11 no hit", cmp_hit, 0);
    ext_pulse();
    rd('h14, rv);
    chk("R10 one step", rv, 2);
    chk("R11 hit", cmp_hit, 1);
    ext_pulse(); ext_pulse();
    rd('h14, rv);
    chk("R10 at zero", rv, 0);
    chk("R10 no flag yet", irq, 0);
    ext_pulse();
    chk("R10 flag on wrap", irq, 1);
    rd('h14, rv);
    chk("R10 reloaded", rv, 3);
    stop_all();
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_load();
    t_period(5, 0, "R4 div2 period");
    t_period(0, 3, "R4 zero count period");
    t_period(5, 2, "R5 prescaled period");
    t_reload_change();
    t_stop();
    t_oneshot();
    t_ext();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule